// File: doc/BRIEF.md
# Receive error-counting status register

This block is the 16-bit status word of a serial port that buffers received bytes in a 16-entry FIFO. Every stored byte carries two error tags: parity and framing. Two 4-bit counters report how many of the bytes now held have each error. The counters follow the FIFO's live contents. They go up on an accepted push and down on a pop, so they are not a history of past errors. The head byte's two tags are shown directly in two read-only bits.

Six sticky event flags sit in the low byte. They report receive errors, transmit end, transmit buffer empty, a line break, the receive trigger level and data ready. Hardware sets these flags. Software clears one only by first reading it as 1 and then writing 0 to it. A write of 1 never sets a flag. A 0 written without the earlier read does nothing.

The receiver pushes bytes through the push port and takes them out through the pop port. The CPU reads and writes the status word through a register bus with read and write strobes. The read data is combinational.

Top module: `serial_status_reg`

## Requirements
- R1: After reset the status word reads 0x0060: bit 6 (transmit end) and bit 5 (transmit buffer empty) are 1, and every other bit is 0.
- R2: The layout of the status word is fixed. Bits [15:12] hold the parity-error count and bits [11:8] hold the framing-error count. Bits 7 to 0 are: error, transmit end, transmit buffer empty, break, head framing error, head parity error, receive trigger, data ready.
- R3: Each count equals the number of bytes now in the FIFO that carry that error, taken modulo 16. With 16 such bytes stored, the field reads 0. A push and a pop in the same cycle both take effect.
- R4: A push into a full FIFO is dropped. The counts and the stored bytes stay unchanged.
- R5: Writing 1 to a sticky flag (bits 7, 6, 5, 4, 1, 0) never sets it and never changes it.
- R6: Writing 0 clears a sticky flag only if a register read returned that flag as 1 after it was last set. Otherwise the write has no effect.
- R7: Bits 15 to 8, bit 3 and bit 2 ignore writes.
- R8: Bit 3 and bit 2 show the framing and parity tags of the byte at the head of the FIFO. Both read 0 when the FIFO is empty.
- R9: If a hardware set event and a valid clearing write arrive in the same cycle, the flag stays set. A new set event also cancels an earlier read, so the next write of 0 needs a fresh read first.
- R10: The error flag (bit 7) is set by any accepted push whose byte carries either error. The receive trigger flag (bit 1) is set when the fill level rises from below 8 to 8 or more.
- R11: One-cycle pulses on the transmit-end, transmit-empty, break and data-ready event inputs set bits 6, 5, 4 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | CPU read strobe for the status word |
| reg_wr | input | 1 | CPU write strobe |
| reg_wdata | input | 16 | CPU write data |
| reg_rdata | output | 16 | Status word |
| rx_push | input | 1 | Push a received byte |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity-error tag of the pushed byte |
| rx_ferr | input | 1 | Framing-error tag of the pushed byte |
| rx_pop | input | 1 | Remove the head byte |
| rx_head | output | 8 | Head byte of the FIFO |
| rx_empty | output | 1 | FIFO holds no bytes |
| ev_tend | input | 1 | Transmit-end event |
| ev_tdfe | input | 1 | Transmit-buffer-empty event |
| ev_brk | input | 1 | Break detected event |
| ev_dr | input | 1 | Data-ready event |

## Verification
The assertions check several things on every cycle. Neither count may exceed the fill level. A push into a full FIFO must leave the level and both counts unchanged. The head-tag bits must read 0 when the FIFO is empty. A flag that was not read since it was set must survive the next cycle. A flag must not rise without its hardware event, and a set event must leave its flag at 1. Other behaviour shows only in the bench's scenarios: the counts following a mixed push/pop sequence, the wrap to 0 at 16 stored errored bytes, the full read-then-write clearing handshake, and the rule that a set event cancels an earlier read.

// File: rtl/serial_status_reg.sv
module serial_status_reg #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_pop,
  output logic [7:0]  rx_head,
  output logic        rx_empty,
  input  logic        ev_tend,
  input  logic        ev_tdfe,
  input  logic        ev_brk,
  input  logic        ev_dr
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [7:0] STICKY    = 8'hF3;
  localparam logic [7:0] FLAG_INIT = 8'h60;

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] lvl_q, lvl_n, pcnt_q, fcnt_q;
  logic [7:0]    flag_q, armed_q, set_v, clr_v;
  logic [9:0]    head;
  logic          push_ok, pop_ok, rdf_set, er_set;

  assign head     = mem[rd_ptr];
  assign rx_head  = head[7:0];
  assign rx_empty = (lvl_q == '0);
  assign push_ok  = rx_push && (lvl_q != LW'(DEPTH));
  assign pop_ok   = rx_pop && !rx_empty;
  assign lvl_n    = lvl_q + LW'(push_ok) - LW'(pop_ok);

  assign er_set  = push_ok && (rx_perr || rx_ferr);
  assign rdf_set = (lvl_q < LW'(TRIG)) && (lvl_n >= LW'(TRIG));
  assign set_v   = {er_set, ev_tend, ev_tdfe, ev_brk, 2'b00, rdf_set, ev_dr};
  assign clr_v   = {8{reg_wr}} & ~reg_wdata[7:0] & armed_q & flag_q & STICKY;

  assign reg_rdata = {4'(pcnt_q), 4'(fcnt_q), flag_q[7:4],
                      head[8] & ~rx_empty, head[9] & ~rx_empty, flag_q[1:0]};

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= {rx_perr, rx_ferr, rx_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      lvl_q   <= '0;
      pcnt_q  <= '0;
      fcnt_q  <= '0;
      flag_q  <= FLAG_INIT;
      armed_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      lvl_q   <= lvl_n;
      pcnt_q  <= pcnt_q + LW'(push_ok & rx_perr) - LW'(pop_ok & head[9]);
      fcnt_q  <= fcnt_q + LW'(push_ok & rx_ferr) - LW'(pop_ok & head[8]);
      flag_q  <= (flag_q & ~clr_v) | set_v;
      armed_q <= (armed_q | ({8{reg_rd}} & flag_q)) & ~clr_v & ~set_v & STICKY;
    end
  end
endmodule

// File: rtl/serial_status_reg_chk.sv
module serial_status_reg_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rx_push,
  input logic                     rx_pop,
  input logic                     rx_empty,
  input logic                     ev_tend,
  input logic                     ev_dr,
  input logic [15:0]              reg_rdata,
  input logic [$clog2(DEPTH):0]   lvl,
  input logic [$clog2(DEPTH):0]   pcnt,
  input logic [$clog2(DEPTH):0]   fcnt,
  input logic [7:0]               flags,
  input logic [7:0]               armed
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [7:0] STICKY = 8'hF3;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt <= lvl) && (fcnt <= lvl));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LW'(DEPTH) && rx_push && !rx_pop) |=> ($stable(lvl) && $stable(pcnt) && $stable(fcnt)));

  assert_no_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[0] && !ev_dr) |=> !reg_rdata[0]);

  assert_unarmed_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~armed & STICKY)) |=> (($past(flags & ~armed & STICKY) & ~flags) == 8'h00));

  assert_empty_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (reg_rdata[3:2] == 2'b00));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tend |=> reg_rdata[6]);
endmodule

bind serial_status_reg serial_status_reg_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop), .rx_empty(rx_empty),
  .ev_tend(ev_tend), .ev_dr(ev_dr), .reg_rdata(reg_rdata), .lvl(lvl_q),
  .pcnt(pcnt_q), .fcnt(fcnt_q), .flags(flag_q), .armed(armed_q)
);

// File: tb/tb_serial_status_reg.sv
module tb_serial_status_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_pop = 0;
  logic [7:0] rx_byte = '0, rx_head;
  logic rx_empty;
  logic ev_tend = 0, ev_tdfe = 0, ev_brk = 0, ev_dr = 0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_status_reg dut (.*);

  // {push, pop, perr, ferr, expected bits [15:8]}
  localparam logic [11:0] VEC [9] = '{
    {4'b1010, 8'h10}, {4'b1001, 8'h11}, {4'b1011, 8'h22},
    {4'b1100, 8'h12}, {4'b0100, 8'h11}, {4'b1010, 8'h21},
    {4'b0100, 8'h10}, {4'b0100, 8'h10}, {4'b0100, 8'h00}};

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic push(logic p, logic f);
    rx_push = 1; rx_perr = p; rx_ferr = f; rx_byte = rx_byte + 8'd1;
    tick;
    rx_push = 0; rx_perr = 0; rx_ferr = 0;
  endtask

  task automatic pop; rx_pop = 1; tick; rx_pop = 0; endtask
  task automatic rd;  reg_rd = 1; tick; reg_rd = 0; endtask
  task automatic wr(logic [15:0] d); reg_wr = 1; reg_wdata = d; tick; reg_wr = 0; endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset value", reg_rdata, 16'h0060);
    check("R1 reset empty", {15'd0, rx_empty}, 16'd1);

    for (int i = 0; i < 9; i++) begin
      rx_push = VEC[i][11]; rx_pop = VEC[i][10];
      rx_perr = VEC[i][9];  rx_ferr = VEC[i][8];
      rx_byte = rx_byte + 8'd1;
      tick;
      rx_push = 0; rx_pop = 0; rx_perr = 0; rx_ferr = 0;
      check($sformatf("R3 R2 counts vector %0d", i), {8'h00, reg_rdata[15:8]}, {8'h00, VEC[i][7:0]});
    end

    push(1, 0);
    check("R8 head parity tag", {14'd0, reg_rdata[3:2]}, 16'd1);
    pop;
    check("R8 empty head tags", {14'd0, reg_rdata[3:2]}, 16'd0);

    rd; wr(16'h0000);
    check("R6 read then clear all", reg_rdata, 16'h0000);

    for (int i = 0; i < 16; i++) push(1, 1);
    check("R3 R10 sixteen errored wrap to zero, ER and RDF set", reg_rdata, 16'h008E);

    push(1, 1);
    pop;
    check("R4 full push dropped", reg_rdata, 16'hFF8E);

    wr(16'hFFFF);
    check("R5 R7 write ones ignored", reg_rdata, 16'hFF8E);
    wr(16'h0000);
    check("R6 R7 zero without read ignored", reg_rdata, 16'hFF8E);
    rd; wr(16'h0000);
    check("R6 read then zero clears", reg_rdata, 16'hFF0C);

    ev_tend = 1; ev_tdfe = 1; ev_dr = 1; tick; ev_tend = 0; ev_tdfe = 0; ev_dr = 0;
    check("R11 events set flags", reg_rdata, 16'hFF6D);
    ev_brk = 1; tick; ev_brk = 0;
    check("R11 break event", reg_rdata, 16'hFF7D);

    rd;
    ev_brk = 1; reg_wr = 1; reg_wdata = 16'h0000; tick; reg_wr = 0; ev_brk = 0;
    check("R9 set wins over clear", reg_rdata, 16'hFF1C);
    wr(16'h0000);
    check("R9 set event disarms", reg_rdata, 16'hFF1C);
    rd; wr(16'hFFEF);
    check("R6 clear single flag", reg_rdata, 16'hFF0C);

    for (int i = 0; i < 15; i++) pop;
    check("R3 drained counts", reg_rdata, 16'h0000);
    pop;
    check("R3 pop on empty ignored", {15'd0, rx_empty}, 16'd1);

    finish_run();
  end
endmodule